// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs one external transfer at a time over a 16-bit pin group that carries both the address and the data. Each transfer is split into four phases. T1 puts the address on the pins and raises an address strobe. T2, T3 and T4 carry data: a write drives the data, and a read leaves the pins floating and samples them. T3 repeats as a wait state for as long as the combined ready is low. The combined ready is the OR of a synchronous ready and an asynchronous ready that first passes through a flop synchronizer.

An internal requester offers an address, write data, a direction flag, a high-byte enable and a per-request address-suppress flag. The requester sees `req_ready` high only while the sequencer is idle or in T4, so transfers can run back to back. A hold request takes priority over new work. Once the current transfer ends, the sequencer parks in a hold state with every pin output disabled. While reset is asserted, the pins are floated and the word present on them is copied into a configuration register on every clock. That register keeps its value after reset is released.

Top module: `adbus_seq`

## Requirements
- R1: While reset is asserted and right after it, `phase_o` reads idle and `ale`, `ad_oe_lo`, `ad_oe_hi`, `done` and `hold_ack` are all 0. The `phase_o` code values are: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 hold.
- R2: `cfg_word` takes the value of `ad_in` at the last rising clock edge before reset is released. After release it does not change.
- R3: In the cycle after a request is accepted, the sequencer is in T1. In T1, `ale` is 1 for that single cycle, `ad_out` equals the request address and `ad_oe_lo` is 1.
- R4: In T1, `ad_oe_hi` is 1 unless the accepted request had `req_addr_off` set, in which case it is 0. `req_addr_off` has no effect on the low byte.
- R5: For a write, during T2 to T4 `ad_out` equals the write data and `ad_oe_lo` is 1. `ad_oe_hi` is 1 only when `req_hi_en` was set, and 0 otherwise.
- R6: For a read, `ad_oe_lo` and `ad_oe_hi` are both 0 during T2 to T4.
- R7: T2 is always followed by T3. T3 repeats while `srdy` OR the synchronized `ardy` is low at the clock edge that ends it. T4 follows the first T3 in which ready is seen.
- R8: With `srdy` low, a rise of `ardy` ends the wait only after two synchronizer flops. If `ardy` rises during T3 cycle k, the last T3 is cycle k+2.
- R9: For a read, `rd_data` takes the value of `ad_in` at the edge that ends the last T3. It is valid in T4 and holds through later writes until the next read.
- R10: `done` is 1 only in T4, for exactly one cycle per transfer.
- R11: While `hold_req` is high at idle or T4, no transfer starts. The sequencer enters hold, where `hold_ack` is 1 and `ale`, `ad_oe_lo` and `ad_oe_hi` are 0. A transfer already past T1 still runs to T4 first. The sequencer returns to idle the cycle after `hold_req` falls.
- R12: `req_ready` is 1 only in idle or T4 with `hold_req` low. A request is accepted exactly when `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 for write, 0 for read |
| req_hi_en | input | 1 | Drive the upper byte during a write's data phases |
| req_addr_off | input | 1 | Suppress the upper-byte address in T1 |
| hold_req | input | 1 | Request to float the bus between transfers |
| hold_ack | output | 1 | Bus is parked in hold |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready, active high |
| ad_in | input | 16 | Value sensed on the pins |
| ad_out | output | 16 | Value driven onto the pins |
| ad_oe_lo | output | 1 | Output enable, lower byte |
| ad_oe_hi | output | 1 | Output enable, upper byte |
| ale | output | 1 | Address strobe, high in T1 |
| phase_o | output | 3 | Current phase code |
| done | output | 1 | Transfer completes (T4) |
| rd_data | output | 16 | Last read data |
| cfg_word | output | 16 | Word captured during reset |

## Verification
The bench varies the number of wait states from zero up, because a sequencer that tested ready one cycle late, or at T2, would add or drop a T3. An `ardy`-only ready is timed against the two-flop delay; a design that bypassed the synchronizer or added a stage would leave T3 at the wrong cycle. Hold is raised both at idle and in the middle of a transfer. A design that floated too early would cut the transfer short, and one that ignored hold would accept the pending request. The byte-lane enables are checked for every combination of direction, high-byte enable and address suppression, since swapping the lanes or leaking the address-suppress flag into the data phases shows up directly on `ad_oe_hi`.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_HOLD = 3'd5
  } phase_e;

  typedef struct packed {
    logic wr;
    logic hi_en;
    logic addr_off;
  } req_flags_t;

endpackage

// File: rtl/adbus_rdy_sync.sv
module adbus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ardy_i,
  input  logic srdy_i,
  output logic rdy_o
);

  logic [STAGES:0] chain;

  assign chain[0] = ardy_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s+1] <= 1'b0;
      end else begin
        chain[s+1] <= chain[s];
      end
    end
  end

  assign rdy_o = chain[STAGES] | srdy_i;

endmodule

// File: rtl/adbus_fsm.sv
module adbus_fsm
  import adbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   hold_req,
  input  logic   rdy,
  output logic   req_ready,
  output logic   accept,
  output logic   cap_en,
  output phase_e phase
);

  phase_e cur_q, nxt;

  assign req_ready = ((cur_q == PH_IDLE) || (cur_q == PH_T4)) && !hold_req;
  assign accept    = req_ready && req_valid;
  assign cap_en    = (cur_q == PH_T3) && rdy;
  assign phase     = cur_q;

  always_comb begin
    nxt = cur_q;
    case (cur_q)
      PH_IDLE: begin
        if (hold_req)       nxt = PH_HOLD;
        else if (req_valid) nxt = PH_T1;
      end
      PH_T1: nxt = PH_T2;
      PH_T2: nxt = PH_T3;
      PH_T3: if (rdy) nxt = PH_T4;
      PH_T4: begin
        if (hold_req)       nxt = PH_HOLD;
        else if (req_valid) nxt = PH_T1;
        else                nxt = PH_IDLE;
      end
      PH_HOLD: if (!hold_req) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= PH_IDLE;
    end else begin
      cur_q <= nxt;
    end
  end

endmodule

// File: rtl/adbus_pins.sv
module adbus_pins
  import adbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cap_en,
  input  phase_e        phase,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  req_flags_t    req_flags,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          oe_lo,
  output logic          oe_hi,
  output logic          ale,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] addr_q, wdata_q, rd_q;
  req_flags_t    flags_q;
  logic          in_t1, in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      flags_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      flags_q <= req_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en && !flags_q.wr) begin
      rd_q <= ad_in;
    end
  end

  assign in_t1   = (phase == PH_T1);
  assign in_data = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_T4);

  assign ale     = in_t1;
  assign ad_out  = in_t1 ? addr_q : wdata_q;
  assign oe_lo   = in_t1 || (in_data && flags_q.wr);
  assign oe_hi   = (in_t1 && !flags_q.addr_off) ||
                   (in_data && flags_q.wr && flags_q.hi_en);
  assign rd_data = rd_q;

endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_hi_en,
  input  logic          req_addr_off,
  input  logic          hold_req,
  output logic          hold_ack,
  input  logic          srdy,
  input  logic          ardy,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  output logic          ale,
  output logic [2:0]    phase_o,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg_word
);

  logic       rdy, accept, cap_en;
  phase_e     phase;
  req_flags_t flags;
  logic [DW-1:0] cfg_q;

  assign flags = '{wr: req_write, hi_en: req_hi_en, addr_off: req_addr_off};

  adbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ardy_i (ardy),
    .srdy_i (srdy),
    .rdy_o  (rdy)
  );

  adbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hold_req  (hold_req),
    .rdy       (rdy),
    .req_ready (req_ready),
    .accept    (accept),
    .cap_en    (cap_en),
    .phase     (phase)
  );

  adbus_pins #(.DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cap_en    (cap_en),
    .phase     (phase),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_flags (flags),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .oe_lo     (ad_oe_lo),
    .oe_hi     (ad_oe_hi),
    .ale       (ale),
    .rd_data   (rd_data)
  );

  // Configuration word: sampled on every clock while reset is held, frozen after.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= ad_in;
    end
  end

  assign cfg_word = cfg_q;
  assign phase_o  = phase;
  assign done     = (phase == PH_T4);
  assign hold_ack = (phase == PH_HOLD);

endmodule

// File: rtl/adbus_seq_chk.sv
module adbus_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          hold_ack,
  input logic          ad_oe_lo,
  input logic          ad_oe_hi,
  input logic          ale,
  input logic [2:0]    phase_o,
  input logic          done,
  input logic [DW-1:0] cfg_word
);

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_word));

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_low_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe_lo);

  p_hi_needs_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && ad_oe_hi) |-> ad_oe_lo);

  p_t3_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3) |=> (phase_o == 3'd3 || phase_o == 3'd4));

  p_t4_after_t3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd4) |-> ($past(phase_o) == 3'd3));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!ad_oe_lo && !ad_oe_hi && !ale && !req_ready));

  p_start_on_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(req_valid && req_ready));

endmodule

bind adbus_seq adbus_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .hold_ack  (hold_ack),
  .ad_oe_lo  (ad_oe_lo),
  .ad_oe_hi  (ad_oe_hi),
  .ale       (ale),
  .phase_o   (phase_o),
  .done      (done),
  .cfg_word  (cfg_word)
);

// File: tb/adbus_seq_bench.sv
`timescale 1ns/1ps
module adbus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_hi_en, req_addr_off, hold_req, srdy, ardy;
  logic [15:0] req_addr, req_wdata, ad_in;
  logic        req_ready, hold_ack, ad_oe_lo, ad_oe_hi, ale, done;
  logic [15:0] ad_out, rd_data, cfg_word;
  logic [2:0]  phase_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_rd = 16'h0000;
  logic [15:0] cfg_exp;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adbus_seq u_adbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_hi_en(req_hi_en), .req_addr_off(req_addr_off), .hold_req(hold_req),
    .hold_ack(hold_ack), .srdy(srdy), .ardy(ardy), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ale(ale), .phase_o(phase_o),
    .done(done), .rd_data(rd_data), .cfg_word(cfg_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_hi_data(input bit wr, input bit hi);
    return wr & hi;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic check_data_lanes(input bit wr, input bit hi, input logic [15:0] d);
    chk(wr ? "R5 oe_lo" : "R6 oe_lo", ad_oe_lo, wr);
    chk(wr ? "R5 oe_hi" : "R6 oe_hi", ad_oe_hi, exp_hi_data(wr, hi));
    if (wr) chk("R5 data", ad_out, d);
    chk("R1 ale off", ale, 0);
  endtask

  // Start at a negedge where the sequencer is idle or in T4; return at the T4 negedge.
  task automatic do_cycle(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input bit hi, input bit aoff, input int nw,
                          input bit use_ardy, input bit hold_mid);
    int last_t3;
    chk("R12 ready", req_ready, 1);
    req_valid = 1; req_addr = a; req_wdata = d; req_write = wr;
    req_hi_en = hi; req_addr_off = aoff; srdy = 0; ardy = 0;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_addr_off = ~aoff;
    chk("R3 phase T1", phase_o, 1);
    chk("R3 ale", ale, 1);
    chk("R3 addr", ad_out, a);
    chk("R3 oe_lo", ad_oe_lo, 1);
    chk("R4 oe_hi", ad_oe_hi, !aoff);
    chk("R10 done low", done, 0);
    if (hold_mid) hold_req = 1;
    @(negedge clk);
    chk("R7 phase T2", phase_o, 2);
    check_data_lanes(wr, hi, d);
    ad_in = wr ? 16'h0 : d;
    last_t3 = use_ardy ? nw + 2 : nw;
    for (int i = 0; i <= last_t3; i++) begin
      @(negedge clk);
      chk(use_ardy ? "R8 phase T3" : "R7 phase T3", phase_o, 3);
      check_data_lanes(wr, hi, d);
      chk("R10 done low", done, 0);
      if (use_ardy) begin
        if (i == nw) ardy = 1;
      end else begin
        srdy = (i >= nw);
      end
    end
    @(negedge clk);
    chk(use_ardy ? "R8 phase T4" : "R7 phase T4", phase_o, 4);
    chk("R10 done", done, 1);
    check_data_lanes(wr, hi, d);
    if (!wr) last_rd = d;
    chk("R9 rd_data", rd_data, last_rd);
    srdy = 0; ardy = 0; ad_in = 16'($urandom);
    if (hold_mid) begin
      chk("R12 ready held off", req_ready, 0);
      @(negedge clk);
      chk("R11 hold phase", phase_o, 5);
      chk("R11 hold_ack", hold_ack, 1);
      chk("R11 float", {ad_oe_lo, ad_oe_hi, ale}, 0);
      hold_req = 0;
      @(negedge clk);
      chk("R11 back to idle", phase_o, 0);
    end
  endtask

  task automatic idle_step();
    @(negedge clk);
    chk("R10 idle phase", phase_o, 0);
    chk("R10 done after T4", done, 0);
    chk("R1 idle float", {ad_oe_lo, ad_oe_hi, ale}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    rst_n = 0; req_valid = 0; req_write = 0; req_hi_en = 0; req_addr_off = 0;
    hold_req = 0; srdy = 0; ardy = 0; req_addr = 0; req_wdata = 0;
    cfg_exp = 16'hC3A5;
    ad_in = 16'h1111;
    repeat (3) @(negedge clk);
    ad_in = cfg_exp;
    @(negedge clk);
    chk("R1 phase", phase_o, 0);
    chk("R1 outputs", {ale, ad_oe_lo, ad_oe_hi, done, hold_ack}, 0);
    rst_n = 1;
    @(negedge clk);
    ad_in = 16'h7E7E;
    @(negedge clk);
    chk("R2 cfg", cfg_word, cfg_exp);
    chk("R1 after reset", {phase_o, ale, ad_oe_lo, ad_oe_hi, done}, 0);

    // Directed: write all lanes, read, suppressed address, high byte off
    do_cycle(1, 16'hA5A5, 16'h1234, 1, 0, 0, 0, 0); idle_step();
    do_cycle(0, 16'h0F0F, 16'hBEEF, 1, 0, 2, 0, 0); idle_step();
    do_cycle(1, 16'h4242, 16'h9988, 0, 1, 1, 0, 0); idle_step();
    chk("R9 held over write", rd_data, 16'hBEEF);
    do_cycle(0, 16'h1357, 16'h2468, 0, 1, 0, 0, 0);
    // Back to back from T4
    do_cycle(1, 16'h8001, 16'h00FF, 1, 0, 3, 0, 0);
    do_cycle(0, 16'h7FFE, 16'h5A5A, 1, 0, 0, 1, 0); idle_step();
    do_cycle(0, 16'h3333, 16'hC0DE, 1, 0, 1, 1, 0); idle_step();

    // Hold at idle with a pending request
    hold_req = 1; req_valid = 1; req_write = 1;
    #0.1;
    chk("R12 ready with hold", req_ready, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 hold phase", phase_o, 5);
      chk("R11 float", {ad_oe_lo, ad_oe_hi, ale, hold_ack}, 4'b0001);
    end
    req_valid = 0; hold_req = 0;
    @(negedge clk);
    chk("R11 release", phase_o, 0);

    // Hold raised mid-transfer
    do_cycle(1, 16'h6060, 16'h0606, 1, 0, 1, 0, 1);

    // Constrained random
    for (int n = 0; n < 60; n++) begin
      bit chain;
      do_cycle($urandom % 2, 16'($urandom), 16'($urandom), $urandom % 2,
               ($urandom % 4) == 0, $urandom % 5, ($urandom % 4) == 0,
               ($urandom % 8) == 0);
      chain = ($urandom % 3) == 0;
      if (!chain && phase_o == 3'd4) idle_step();
    end
    if (phase_o == 3'd4) idle_step();
    chk("R2 cfg stable", cfg_word, cfg_exp);
    summary();
  end

endmodule